// File: doc/BRIEF.md
# Segment Delay Deviation Locator

This block scores test-path segments of a programmable fabric against their expected timing. For every region of the die it receives three counts: the measured count for a rising transition, the measured count for a falling transition, and the fault-free nominal count for that region. It also receives a programmable threshold. From each record it derives two signed differences from nominal, one per direction. It keeps the larger of the two as the region's deviation. It flags slow-to-rise and slow-to-fall faults separately.

Region records arrive on a valid/ready input stream, and the last record of a sweep is marked. For each accepted record, the block emits a per-region result on a valid/ready output stream. Results are kept in a single output register. The input is back-pressured whenever that register holds a result the consumer has not taken (`res_ready` low). The input is also back-pressured while a clear is asserted, and while a finished sweep's location is being held.

Across the sweep, the block tracks the region with the largest deviation. One cycle after the last record is accepted, it presents that region's id and deviation. This location is held until a synchronous clear. A sticky per-region fault map records every region that failed during the sweep.

Top module: `seg_delay_locator`

## Requirements
- R1: After reset, and in the cycle after `clr` is sampled high, `res_valid` and `loc_valid` are 0 and `fault_map` is all zeros.
- R2: `in_ready` equals `!clr && !loc_valid && (!res_valid || res_ready)`. A record is taken on a clock edge where `in_valid && in_ready`. While `res_valid` is 1 and `res_ready` is 0, the result fields stay unchanged.
- R3: `res_dev` is the larger of (rise − nominal) and (fall − nominal). It is a signed two's-complement value CNT_W+1 bits wide and is negative when both measurements beat nominal.
- R4: `res_rise_slow` is 1 exactly when (rise − nominal) > `thresh`, and `res_fall_slow` is 1 exactly when (fall − nominal) > `thresh`. A difference equal to the threshold passes.
- R5: `res_fault` is the OR of the two slow flags. A faulty region sets bit `id` of `fault_map`, and that bit stays set until clear.
- R6: `loc_id` and `loc_dev` give the accepted region with the largest `res_dev` since the last clear. When two regions have equal deviation, the lower id wins, whatever the arrival order.
- R7: `loc_valid` rises in the cycle after the record with `in_last`=1 is accepted. It stays high with a stable `loc_id` until `clr`, and in that time no record is accepted.
- R8: A record accepted at a clock edge appears on the result port (`res_valid`=1, `res_id`= its id) right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of results, map and location |
| thresh | input | CNT_W | Allowed excess over nominal |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record can be taken |
| in_id | input | ID_W | Region id |
| in_rise | input | CNT_W | Rising-transition count |
| in_fall | input | CNT_W | Falling-transition count |
| in_nom | input | CNT_W | Fault-free nominal count |
| in_last | input | 1 | Final region of the sweep |
| res_valid | output | 1 | Per-region result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_id | output | ID_W | Region id of the result |
| res_dev | output | CNT_W+1 | Signed deviation |
| res_rise_slow | output | 1 | Slow-to-rise flag |
| res_fall_slow | output | 1 | Slow-to-fall flag |
| res_fault | output | 1 | Region failed |
| fault_map | output | N_REG | Sticky per-region fault bits |
| loc_valid | output | 1 | Location of worst region valid |
| loc_id | output | ID_W | Id of worst region |
| loc_dev | output | CNT_W+1 | Deviation of worst region |

## Verification
The bench uses several corner cases, each with the error it would catch:
- A difference exactly equal to the threshold next to one just above it. A greater-or-equal compare would flag the first.
- Regions whose measurements all beat nominal. An unsigned difference would turn these into huge positive deviations and pull the location toward them.
- Equal deviations arriving high id first. A tracker that keeps the first or the last arrival would report the wrong region.
- Full-scale counts, to catch a deviation width that overflows.
- Back-pressure, a clear raised while a record is offered, and records offered after a sweep has finished. These expose a design that drops results, takes records it should refuse, or lets the held location drift.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  // Direction indices used by the scoring lanes.
  localparam int DIR_RISE = 0;
  localparam int DIR_FALL = 1;
  localparam int N_DIR    = 2;

  typedef struct packed {
    logic fall_slow;
    logic rise_slow;
  } slow_t;
endpackage

// File: rtl/sdl_score.sv
module sdl_score #(
  parameter int CNT_W = 16,
  localparam int DEV_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]        rise,
  input  logic [CNT_W-1:0]        fall,
  input  logic [CNT_W-1:0]        nom,
  input  logic [CNT_W-1:0]        thresh,
  output logic signed [DEV_W-1:0] dev,
  output sdl_pkg::slow_t          slow
);
  logic [sdl_pkg::N_DIR-1:0][CNT_W-1:0] meas;
  logic signed [DEV_W-1:0] lane_dev [sdl_pkg::N_DIR];
  logic [sdl_pkg::N_DIR-1:0] lane_slow;
  logic signed [DEV_W-1:0] thr_s;

  assign meas[sdl_pkg::DIR_RISE] = rise;
  assign meas[sdl_pkg::DIR_FALL] = fall;
  assign thr_s = $signed({1'b0, thresh});

  // One identical scoring lane per transition direction.
  for (genvar g = 0; g < sdl_pkg::N_DIR; g++) begin : g_lane
    assign lane_dev[g]  = $signed({1'b0, meas[g]}) - $signed({1'b0, nom});
    assign lane_slow[g] = lane_dev[g] > thr_s;
  end

  assign dev = (lane_dev[sdl_pkg::DIR_RISE] > lane_dev[sdl_pkg::DIR_FALL])
               ? lane_dev[sdl_pkg::DIR_RISE] : lane_dev[sdl_pkg::DIR_FALL];
  assign slow.rise_slow = lane_slow[sdl_pkg::DIR_RISE];
  assign slow.fall_slow = lane_slow[sdl_pkg::DIR_FALL];
endmodule

// File: rtl/sdl_result_reg.sv
module sdl_result_reg #(
  parameter int CNT_W = 16,
  parameter int N_REG = 16,
  localparam int ID_W  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int DEV_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    take,
  input  logic                    drain,
  input  logic [ID_W-1:0]         id,
  input  logic signed [DEV_W-1:0] dev,
  input  sdl_pkg::slow_t          slow,
  output logic                    res_valid,
  output logic [ID_W-1:0]         res_id,
  output logic signed [DEV_W-1:0] res_dev,
  output logic                    res_rise_slow,
  output logic                    res_fall_slow,
  output logic                    res_fault,
  output logic [N_REG-1:0]        fault_map
);
  logic bad;
  assign bad = slow.rise_slow | slow.fall_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_id        <= '0;
      res_dev       <= '0;
      res_rise_slow <= 1'b0;
      res_fall_slow <= 1'b0;
      res_fault     <= 1'b0;
    end else if (clr) begin
      res_valid <= 1'b0;
    end else if (take) begin
      res_valid     <= 1'b1;
      res_id        <= id;
      res_dev       <= dev;
      res_rise_slow <= slow.rise_slow;
      res_fall_slow <= slow.fall_slow;
      res_fault     <= bad;
    end else if (drain) begin
      res_valid <= 1'b0;
    end
  end

  // Sticky per-region fault bits.
  for (genvar g = 0; g < N_REG; g++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fault_map[g] <= 1'b0;
      else if (clr)
        fault_map[g] <= 1'b0;
      else if (take && bad && (id == ID_W'(g)))
        fault_map[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sdl_peak_track.sv
module sdl_peak_track #(
  parameter int CNT_W = 16,
  parameter int N_REG = 16,
  localparam int ID_W  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int DEV_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    take,
  input  logic                    last,
  input  logic [ID_W-1:0]         id,
  input  logic signed [DEV_W-1:0] dev,
  output logic                    loc_valid,
  output logic [ID_W-1:0]         loc_id,
  output logic signed [DEV_W-1:0] loc_dev
);
  logic have;
  logic wins;

  // Larger deviation wins; on equal deviation the lower id wins.
  assign wins = !have || (dev > loc_dev) || ((dev == loc_dev) && (id < loc_id));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have      <= 1'b0;
      loc_valid <= 1'b0;
      loc_id    <= '0;
      loc_dev   <= '0;
    end else if (clr) begin
      have      <= 1'b0;
      loc_valid <= 1'b0;
    end else if (take) begin
      have <= 1'b1;
      if (wins) begin
        loc_id  <= id;
        loc_dev <= dev;
      end
      if (last) loc_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/seg_delay_locator.sv
module seg_delay_locator #(
  parameter int CNT_W = 16,
  parameter int N_REG = 16,
  localparam int ID_W  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int DEV_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [CNT_W-1:0]        thresh,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ID_W-1:0]         in_id,
  input  logic [CNT_W-1:0]        in_rise,
  input  logic [CNT_W-1:0]        in_fall,
  input  logic [CNT_W-1:0]        in_nom,
  input  logic                    in_last,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [ID_W-1:0]         res_id,
  output logic signed [DEV_W-1:0] res_dev,
  output logic                    res_rise_slow,
  output logic                    res_fall_slow,
  output logic                    res_fault,
  output logic [N_REG-1:0]        fault_map,
  output logic                    loc_valid,
  output logic [ID_W-1:0]         loc_id,
  output logic signed [DEV_W-1:0] loc_dev
);
  logic                    take;
  logic signed [DEV_W-1:0] sc_dev;
  sdl_pkg::slow_t          sc_slow;

  assign in_ready = !clr && !loc_valid && (!res_valid || res_ready);
  assign take     = in_valid && in_ready;

  sdl_score #(.CNT_W(CNT_W)) u_score (
    .rise(in_rise), .fall(in_fall), .nom(in_nom), .thresh(thresh),
    .dev(sc_dev), .slow(sc_slow)
  );

  sdl_result_reg #(.CNT_W(CNT_W), .N_REG(N_REG)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .drain(res_ready),
    .id(in_id), .dev(sc_dev), .slow(sc_slow),
    .res_valid(res_valid), .res_id(res_id), .res_dev(res_dev),
    .res_rise_slow(res_rise_slow), .res_fall_slow(res_fall_slow),
    .res_fault(res_fault), .fault_map(fault_map)
  );

  sdl_peak_track #(.CNT_W(CNT_W), .N_REG(N_REG)) u_peak (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .last(in_last),
    .id(in_id), .dev(sc_dev),
    .loc_valid(loc_valid), .loc_id(loc_id), .loc_dev(loc_dev)
  );
endmodule

// File: rtl/sdl_locator_chk.sv
module sdl_locator_chk #(
  parameter int CNT_W = 16,
  parameter int N_REG = 16,
  localparam int ID_W  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int DEV_W = CNT_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [ID_W-1:0]         in_id,
  input logic                    res_valid,
  input logic                    res_ready,
  input logic [ID_W-1:0]         res_id,
  input logic signed [DEV_W-1:0] res_dev,
  input logic                    res_fault,
  input logic [N_REG-1:0]        fault_map,
  input logic                    loc_valid,
  input logic [ID_W-1:0]         loc_id
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && !loc_valid && fault_map == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !clr) |=> (res_valid && $stable(res_id) && $stable(res_dev)));

  p_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> fault_map[res_id]);

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> !in_ready);

  p_loc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !clr) |=> (loc_valid && $stable(loc_id)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (res_valid && res_id == $past(in_id)));
endmodule

bind seg_delay_locator sdl_locator_chk #(.CNT_W(CNT_W), .N_REG(N_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .in_id(in_id), .res_valid(res_valid), .res_ready(res_ready), .res_id(res_id),
  .res_dev(res_dev), .res_fault(res_fault), .fault_map(fault_map),
  .loc_valid(loc_valid), .loc_id(loc_id)
);

// File: tb/seg_delay_locator_tb.sv
`timescale 1ns/1ps
module seg_delay_locator_tb;
  localparam int CW = 16;
  localparam int NR = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, clr, in_valid, in_ready, in_last, res_valid, res_ready;
  logic [CW-1:0] thresh, in_rise, in_fall, in_nom;
  logic [IW-1:0] in_id, res_id, loc_id;
  logic signed [CW:0] res_dev, loc_dev;
  logic res_rise_slow, res_fall_slow, res_fault, loc_valid;
  logic [NR-1:0] fault_map;

  seg_delay_locator #(.CNT_W(CW), .N_REG(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .thresh(thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_rise(in_rise), .in_fall(in_fall), .in_nom(in_nom), .in_last(in_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_id(res_id),
    .res_dev(res_dev), .res_rise_slow(res_rise_slow), .res_fall_slow(res_fall_slow),
    .res_fault(res_fault), .fault_map(fault_map),
    .loc_valid(loc_valid), .loc_id(loc_id), .loc_dev(loc_dev)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model state
  int m_rv = 0, m_rid = 0, m_rdev = 0, m_rs = 0, m_fs = 0;
  int m_lv = 0, m_have = 0, m_max = 0, m_mid = 0;
  logic [NR-1:0] m_map = '0;
  int thr = 10;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit iv, int id, int r, int f, int n, bit last, bit rr, bit c);
    bit exp_rdy;
    int rd, fd, dv, rs, fs;
    @(negedge clk);
    in_valid = iv; in_id = IW'(id); in_rise = CW'(r); in_fall = CW'(f);
    in_nom = CW'(n); in_last = last; res_ready = rr; clr = c; thresh = CW'(thr);
    #1;
    exp_rdy = !c && (m_lv == 0) && ((m_rv == 0) || rr);
    chk("R2", "in_ready", in_ready, exp_rdy);
    chk("R1", "res_valid", res_valid, m_rv);
    if (m_rv != 0) begin
      chk("R8", "res_id", res_id, m_rid);
      chk("R3", "res_dev", $signed(res_dev), m_rdev);
      chk("R4", "res_rise_slow", res_rise_slow, m_rs);
      chk("R4", "res_fall_slow", res_fall_slow, m_fs);
      chk("R5", "res_fault", res_fault, (m_rs | m_fs));
    end
    chk("R5", "fault_map", fault_map, m_map);
    chk("R7", "loc_valid", loc_valid, m_lv);
    if (m_lv != 0) begin
      chk("R6", "loc_id", loc_id, m_mid);
      chk("R6", "loc_dev", $signed(loc_dev), m_max);
    end
    // model update for the coming edge
    if (c) begin
      m_rv = 0; m_lv = 0; m_map = '0; m_have = 0;
    end else if (iv && exp_rdy) begin
      rd = r - n; fd = f - n;
      dv = (rd > fd) ? rd : fd;
      rs = (rd > thr) ? 1 : 0;
      fs = (fd > thr) ? 1 : 0;
      m_rv = 1; m_rid = id; m_rdev = dv; m_rs = rs; m_fs = fs;
      if ((rs | fs) != 0) m_map[id] = 1'b1;
      if (m_have == 0 || dv > m_max || (dv == m_max && id < m_mid)) begin
        m_max = dv; m_mid = id;
      end
      m_have = 1;
      if (last) m_lv = 1;
    end else if (m_rv != 0 && rr) begin
      m_rv = 0;
    end
  endtask

  task automatic beat(int id, int r, int f, int n, bit last);
    cyc(1, id, r, f, n, last, 1, 0);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; in_valid = 0; in_id = '0; in_rise = '0; in_fall = '0;
    in_nom = '0; in_last = 0; res_ready = 1; thresh = CW'(thr);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle(2);                                  // R1 reset state

    // Sweep A: threshold edge, signed deviations, tie (ids 1 and 4, lower wins)
    beat(0, 105, 103, 100, 0);                // dev 5, pass
    beat(1, 100, 120, 100, 0);                // dev 20, slow-to-fall
    beat(2, 110, 95, 100, 0);                 // R4: equal threshold passes
    beat(3, 111, 90, 100, 0);                 // R4: slow-to-rise
    beat(4, 80, 120, 100, 0);                 // dev 20 tie, R6 keeps id 1
    beat(5, 90, 92, 100, 1);                  // negative dev R3, last
    idle(2);
    cyc(1, 6, 500, 500, 0, 0, 1, 0);          // R7: refused after sweep
    idle(1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);              // R1 clear
    idle(1);

    // Sweep B: all below nominal, back-pressure, tie arriving high id first
    cyc(1, 7, 40, 45, 50, 0, 0, 0);           // accepted, dev -5
    cyc(1, 3, 45, 44, 50, 0, 0, 0);           // R2 held off
    cyc(1, 3, 45, 44, 50, 0, 0, 0);
    cyc(1, 3, 45, 44, 50, 0, 1, 0);           // accepted now, dev -5 tie
    cyc(1, 9, 10, 20, 50, 1, 1, 0);           // dev -30, last
    idle(2);                                  // R6: loc id 3, dev -5
    cyc(0, 0, 0, 0, 0, 0, 1, 1);

    // Sweep C: full-scale counts and clear while a record is offered
    beat(2, 65535, 0, 0, 0);                  // dev +65535
    cyc(1, 4, 900, 900, 0, 0, 1, 1);          // R1: clear wins, record not taken
    beat(8, 0, 0, 65535, 0);                  // dev -65535
    beat(15, 65535, 65535, 65534, 1);         // dev 1, pass
    idle(3);
    thr = 0;
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    beat(12, 1, 0, 0, 1);                     // R4 with threshold 0
    idle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule